// File: doc/BRIEF.md
# SD Card Clock Generator with Settle Handshake

This block turns a base clock into the clock that drives an SD card. A single 16-bit control word, written by software, turns the internal divider on, picks the divide ratio and opens the card clock output. A read-only flag in the same word tells software when the divided clock has settled. Bring-up takes three steps. First, write the divisor with the internal enable set. Second, poll until the settled flag reads 1. Third, set the output enable. Writing an all-zero word stops everything.

Control word layout: bit 0 is the internal enable, bit 1 is the settled flag (read-only), bit 2 is the card clock output enable, bits 15:8 hold the divisor field d, and bits 7:3 read as 0. For d from 1 to 128 the card clock period is 2*d base cycles. Software uses powers of two, and d = 128 gives divide-by-256. For d = 0 the base clock passes straight through.

The controller is a four-state machine:
- OFF: divider idle, flag low, output closed.
- SETTLE: counting `SETTLE_CYCLES` base cycles.
- READY: settled, output closed.
- RUN: settled, output open.

Its transitions:
- OFF→SETTLE when a write sets the internal enable.
- SETTLE→READY when the count is done.
- READY→RUN when the output enable is set.
- RUN→READY when a write clears the output enable.
- SETTLE/READY/RUN→SETTLE when a write keeps the internal enable set but changes the divisor; the count restarts.
- Any state→OFF when a write clears the internal enable.

The output gate and the clock source select change only on the falling base-clock edge, and only while the selected source is low. This keeps runt pulses off the output.

Top module: `sd_clock_gen`

## Requirements
- R1: Bits 0, 2 and 15:8 read back the last written value on the cycle after a write. Bits 7:3 read 0. Bit 1 ignores writes and reads the settled flag.
- R2: The settled flag (bit 1) rises exactly `SETTLE_CYCLES` base clock edges after the write edge that moves the block from OFF to SETTLE. It stays high until a write clears it.
- R3: The settled flag is never high while the internal enable (bit 0) is 0.
- R4: A write with bit 0 = 0, including an all-zero word, clears the settled flag on the next cycle and stops all card clock pulses.
- R5: A write that keeps bit 0 = 1 but changes bits 15:8 clears the settled flag on the next cycle. The flag rises again a full `SETTLE_CYCLES` edges after that write.
- R6: The card clock output has no pulses unless the flag is high and bit 2 is 1. Setting bits 0 and 2 in one write gives no pulses during the settle period.
- R7: For a divisor field d of 1..128, the card clock period is 2*d base cycles, and the high time is d base cycles.
- R8: For a divisor field of 0, the card clock follows the base clock: high in the base high phase and low in the base low phase.
- R9: No high pulse on the card clock is shorter than half a base clock period. This holds across enable, disable and divisor changes, including changes to or from 0.
- R10: A write that clears only bit 2 stops the card clock pulses and leaves the settled flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word with settled flag |
| sd_clk_out | output | 1 | Gated, divided card clock |

## Verification
The hardest situation to reach is a divisor change while the output is running, especially a change across zero. In that case the clock source itself switches between the divided clock and the raw base clock, and a careless gate would emit a sliver of a pulse. The stimulus rewrites the divisor directly from RUN, without an intermediate all-zero write, using random power-of-two values that include 0. A monitor on the output pin records the width of every high pulse over the whole run. Separate directed writes land during the settle count, to show that an early output enable stays held back.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READY  = 2'd2,
        ST_RUN    = 2'd3
    } clk_state_e;
endpackage

// File: rtl/sdclk_ctrl_fsm.sv
`timescale 1ns/1ps
module sdclk_ctrl_fsm
    import sdclk_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_int_en,
    input  logic wr_out_en,
    input  logic div_change,
    input  logic out_en_q,
    output logic settled,
    output logic gate_req,
    output logic running
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    clk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (wr_en && wr_int_en) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end
            end
            ST_SETTLE: begin
                if (wr_en && !wr_int_en) begin
                    state_d = ST_OFF;
                end else if (wr_en && div_change) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_READY;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_READY: begin
                if (wr_en) begin
                    if (!wr_int_en) begin
                        state_d = ST_OFF;
                    end else if (div_change) begin
                        state_d = ST_SETTLE;
                        cnt_d   = '0;
                    end else if (wr_out_en) begin
                        state_d = ST_RUN;
                    end
                end else if (out_en_q) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (wr_en) begin
                    if (!wr_int_en) begin
                        state_d = ST_OFF;
                    end else if (div_change) begin
                        state_d = ST_SETTLE;
                        cnt_d   = '0;
                    end else if (!wr_out_en) begin
                        state_d = ST_READY;
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        settled  = (state_q == ST_READY) || (state_q == ST_RUN);
        gate_req = (state_q == ST_RUN);
        running  = (state_q != ST_OFF);
    end
endmodule

// File: rtl/sdclk_divider.sv
`timescale 1ns/1ps
module sdclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             div_clk
);
    logic [DIV_W-1:0] cnt_q;
    logic             div_clk_q;
    logic [DIV_W-1:0] half_last;

    // a zero field runs the divider at its fastest rate so a pending high phase still ends cleanly
    assign half_last = (div == '0) ? '0 : div - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            div_clk_q <= 1'b0;
        end else if (run || div_clk_q) begin
            if (cnt_q >= half_last) begin
                cnt_q     <= '0;
                div_clk_q <= ~div_clk_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign div_clk = div_clk_q;
endmodule

// File: rtl/sdclk_out_gate.sv
`timescale 1ns/1ps
module sdclk_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    input  logic want_base,
    input  logic div_clk,
    output logic gate_on,
    output logic sd_clk_out
);
    logic gate_q;
    logic base_sel_q;
    logic src_low;

    // on the falling base edge the raw base source is low by definition
    assign src_low = base_sel_q | ~div_clk;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q     <= 1'b0;
            base_sel_q <= 1'b0;
        end else begin
            if (!gate_q) begin
                base_sel_q <= want_base;
            end
            if (src_low) begin
                gate_q <= gate_req & (base_sel_q == want_base);
            end
        end
    end

    assign gate_on    = gate_q;
    assign sd_clk_out = gate_q & (base_sel_q ? clk : div_clk);
endmodule

// File: rtl/sd_clock_gen.sv
`timescale 1ns/1ps
module sd_clock_gen #(
    parameter int DIV_W         = 8,
    parameter int SETTLE_CYCLES = 16,
    parameter int REG_W         = DIV_W + 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             sd_clk_out
);
    localparam int BIT_INT = 0;
    localparam int BIT_OUT = 2;
    localparam int DIV_LSB = 8;

    logic             int_en_q;
    logic             out_en_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] wr_div;
    logic             div_change;
    logic             settled;
    logic             gate_req;
    logic             running;
    logic             div_clk;
    logic             gate_on;

    assign wr_div     = wr_data[DIV_LSB +: DIV_W];
    assign div_change = (wr_div != div_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_en_q <= 1'b0;
            out_en_q <= 1'b0;
            div_q    <= '0;
        end else if (wr_en) begin
            int_en_q <= wr_data[BIT_INT];
            out_en_q <= wr_data[BIT_OUT];
            div_q    <= wr_div;
        end
    end

    sdclk_ctrl_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_int_en  (wr_data[BIT_INT]),
        .wr_out_en  (wr_data[BIT_OUT]),
        .div_change (div_change),
        .out_en_q   (out_en_q),
        .settled    (settled),
        .gate_req   (gate_req),
        .running    (running)
    );

    sdclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .div     (div_q),
        .div_clk (div_clk)
    );

    sdclk_out_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_req   (gate_req),
        .want_base  (div_q == '0),
        .div_clk    (div_clk),
        .gate_on    (gate_on),
        .sd_clk_out (sd_clk_out)
    );

    assign rd_data = {div_q, 5'b0, out_en_q, settled, int_en_q};
endmodule

// File: rtl/sdclk_checker.sv
`timescale 1ns/1ps
module sdclk_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             gate_open
);
    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[REG_W-1:8] == $past(wr_data[REG_W-1:8]))
                  && (rd_data[2] == $past(wr_data[2]))
                  && (rd_data[0] == $past(wr_data[0]))
                  && (rd_data[7:3] == 5'b0));

    p_flag_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] && !wr_en) |=> rd_data[1]);

    p_flag_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] |-> rd_data[0]);

    p_disable_drops_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0]) |=> !rd_data[1]);

    p_divisor_drops_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0] && (wr_data[REG_W-1:8] != rd_data[REG_W-1:8])) |=> !rd_data[1]);

    p_gate_after_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> (rd_data[1] && rd_data[2]));
endmodule

bind sd_clock_gen sdclk_checker #(.REG_W(REG_W)) u_sdclk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .gate_open (gate_on)
);

// File: tb/sd_clock_gen_test.sv
`timescale 1ns/1ps
module sd_clock_gen_test;
    localparam int SETTLE = 16;
    localparam real TCLK = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sd_clk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sd_clock_gen #(.DIV_W(8), .SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sd_clk_out(sd_clk_out)
    );

    // output pin monitors
    realtime last_rise = 0.0, prev_rise = 0.0, last_high = 0.0, min_high = 1.0e9;
    int      rise_cnt = 0;
    always @(posedge sd_clk_out) begin
        prev_rise = last_rise;
        last_rise = $realtime;
        rise_cnt++;
    end
    always @(negedge sd_clk_out) begin
        last_high = $realtime - last_rise;
        if (last_high < min_high) min_high = last_high;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [15:0] w, input bit flag);
        return {w[15:8], 5'b0, w[2], flag, w[0]};
    endfunction

    function automatic int exp_period_ps(input int d);
        return (d == 0) ? int'(TCLK * 1000.0) : int'(2.0 * d * TCLK * 1000.0);
    endfunction

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // edges until the flag reads high; no pulses allowed meanwhile
    task automatic wait_flag(output int n, output int rises);
        int r0 = rise_cnt;
        n = 0;
        while (!rd_data[1] && n < 4 * SETTLE) begin
            @(posedge clk);
            #1;
            n++;
        end
        rises = rise_cnt - r0;
    endtask

    task automatic measure(input string req, input int d);
        int per, hi;
        cycles(16 * (d == 0 ? 1 : d) + 12);
        per = int'((last_rise - prev_rise) * 1000.0);
        check(per == exp_period_ps(d), req, $sformatf("period d=%0d", d), per, exp_period_ps(d));
        if (d != 0) begin
            hi = int'(last_high * 1000.0);
            check(hi == int'(d * TCLK * 1000.0), req, $sformatf("high time d=%0d", d), hi, int'(d * TCLK * 1000.0));
        end
    endtask

    task automatic silent(input string req, input string what, input int d);
        cycles(2 * (d == 0 ? 1 : d) + 4);
        rise_cnt = 0;
        cycles(2 * (d == 0 ? 1 : d) * 4 + 8);
        check(rise_cnt == 0, req, what, rise_cnt, 0);
    endtask

    task automatic bring_up(input int d, input string req);
        int n, r;
        write_reg({d[7:0], 8'h01});
        wait_flag(n, r);
        check(n == SETTLE, "R2", "settle edges", n, SETTLE);
        write_reg({d[7:0], 8'h05});
        measure(req, d);
    endtask

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int n, r, d, idx;
        logic [15:0] w;
        void'($urandom(32'h5eed_c10c));
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        check(rd_data == 16'h0000, "R1", "reset word", rd_data, 0);
        check(rise_cnt == 0, "R6", "no pulses after reset", rise_cnt, 0);

        // R1 readback, flag bit ignores writes, R3 flag low with enable clear
        write_reg(16'h40FE);
        check(rd_data == 16'h4004, "R1", "readback", rd_data, 16'h4004);
        silent("R6", "no pulses with internal enable clear", 1);
        check(rd_data[1] == 1'b0, "R3", "flag while disabled", rd_data[1], 0);
        write_reg(16'h0000);

        // R6: output enable written together with internal enable
        write_reg(16'h0405);
        wait_flag(n, r);
        check(n == SETTLE, "R2", "settle edges d=4", n, SETTLE);
        check(r == 0, "R6", "pulses during settle", r, 0);
        measure("R7", 4);

        // R10: clear only the output enable
        write_reg(16'h0401);
        check(rd_data == exp_word(16'h0401, 1'b1), "R10", "flag kept", rd_data, exp_word(16'h0401, 1'b1));
        silent("R10", "pulses after output disable", 4);
        write_reg(16'h0405);
        measure("R7", 4);

        // R5: divisor change while running
        write_reg(16'h0805);
        check(rd_data[1] == 1'b0, "R5", "flag after divisor change", rd_data[1], 0);
        wait_flag(n, r);
        check(n == SETTLE, "R5", "settle restart", n, SETTLE);
        measure("R7", 8);

        // R4: all-zero word
        write_reg(16'h0000);
        check(rd_data == 16'h0000, "R4", "word after stop", rd_data, 0);
        silent("R4", "pulses after stop", 8);

        // R8: pass-through
        bring_up(0, "R8");
        @(posedge clk); #1;
        check(sd_clk_out == 1'b1, "R8", "high phase", sd_clk_out, 1);
        @(negedge clk); #1;
        check(sd_clk_out == 1'b0, "R8", "low phase", sd_clk_out, 0);
        write_reg(16'h0000);
        silent("R4", "pulses after stop d=0", 0);

        // R7: largest divisor
        bring_up(128, "R7");
        write_reg(16'h0000);
        silent("R4", "pulses after stop d=128", 128);

        // random divisor hops straight from RUN, including through zero
        d = 1;
        bring_up(d, "R7");
        for (int it = 0; it < 10; it++) begin
            idx = int'($urandom_range(0, 7));
            d = (idx == 0) ? 0 : (1 << (idx - 1));
            w = {d[7:0], 8'h05};
            if (w[15:8] != rd_data[15:8]) begin
                write_reg(w);
                check(rd_data[1] == 1'b0, "R5", "flag after random hop", rd_data[1], 0);
            end else begin
                write_reg(w);
            end
            wait_flag(n, r);
            check(rd_data[1] == 1'b1, "R2", "flag after random hop", rd_data[1], 1);
            measure("R7", d);
        end

        // random writes with internal enable clear
        for (int it = 0; it < 8; it++) begin
            w = 16'($urandom) & 16'hFFFE;
            write_reg(w);
            cycles(int'($urandom_range(1, 20)));
            check(rd_data == exp_word(w, 1'b0), "R3", "random disabled word", rd_data, exp_word(w, 1'b0));
        end

        check(int'(min_high * 1000.0) >= 2500, "R9", "shortest high pulse ps", int'(min_high * 1000.0), 2500);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule